// File: doc/BRIEF.md
# Nibble-Pass Iterative Multiplier

This block multiplies two 8-bit unsigned numbers into a 16-bit product using one small 4x4 arithmetic cell. The cell forms `a*b + c + s` on 4-bit inputs and returns an 8-bit result. The full product is built in four passes, one for each pairing of operand nibbles. The upper nibble of each pass result is routed back into the `c` and `s` inputs of a later pass, so no separate adder is needed.

A caller pulses `start` together with the two operands. The block takes a copy of the operands on that edge, runs its four passes, and then raises `done` for one cycle with the finished product on `product`. A build parameter decides whether the cell's output is taken directly from its logic or passes through one register. The register shortens the combinational path and adds one cycle of latency.

Top module: `nib_iter_mult`

## Requirements
- R1: While reset is held and on the first cycle after it, `done` is 0 and `product` is 0.
- R2: When `done` is 1, `product` equals the unsigned product of the `op_a` and `op_b` values that were sampled with the accepted `start`. This holds for every pair of operand values, including 0 and 255.
- R3: A `start` is accepted when it is sampled high at a rising edge while the block is idle. With `REG_STAGE` = 0, `done` is high during the cycle that follows the 4th rising edge after the accepting edge.
- R4: `done` is high for exactly one cycle for each accepted `start`.
- R5: A `start` that is sampled while a multiply is in progress is ignored. It does not restart the multiply, it does not change the result or the completion time, and it produces no extra `done` pulse.
- R6: Changes on `op_a` and `op_b` after the accepting edge have no effect on the product.
- R7: `product` keeps its value from one completion until the next completion.
- R8: A `start` that is sampled in the cycle where `done` is high is accepted. Back-to-back multiplies therefore need no idle gap.
- R9: With `REG_STAGE` = 1, the result is the same as in R2, and `done` rises exactly one cycle later than in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Requests a multiply; takes effect only while idle |
| op_a | input | 8 | Multiplicand, unsigned |
| op_b | input | 8 | Multiplier, unsigned |
| product | output | 16 | Result of the latest completed multiply |
| done | output | 1 | One-cycle pulse when `product` has been updated |

## Verification
The bound checker watches several properties on every cycle. It compares `product` against its own copy of the accepted operands whenever `done` is high. It counts the cycles from acceptance to `done` to check the latency. It checks that `done` never lasts two cycles. It checks that the held operands never move while a multiply is running, and that `product` changes only on a completion.

Some behaviour can only be shown by the bench's scenarios. These are that values toggled on the operand pins after acceptance leave the answer alone, that a second `start` during a run produces no extra pulse afterwards, and that a `start` in the completion cycle chains correctly. The bench also sweeps every first operand against a spread of second operands on both the combinational build and the registered build side by side.

// File: rtl/nib_mult_pkg.sv
// Shared widths for the nibble-pass multiplier.
// Assumes the operand splits into exactly two nibbles.
package nib_mult_pkg;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 2 * NIB_W;
    localparam int CELL_W = 2 * NIB_W;
    localparam int PROD_W = 2 * OP_W;
    localparam int PH_W   = 3;
    typedef logic [PH_W-1:0] phase_t;
endpackage

// File: rtl/nib_mac_cell.sv
// Multiply-add-add cell: res = a*b + c + s on W-bit inputs, 2W-bit result.
// The sum never exceeds (2^W-1)^2 + 2*(2^W-1) = 2^(2W)-1, so no carry is lost.
// REG_OUT = 1 places one register on the result (one cycle of latency).
module nib_mac_cell #(
    parameter int W       = 4,
    parameter int REG_OUT = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [W-1:0]   c,
    input  logic [W-1:0]   s,
    output logic [2*W-1:0] res
);
    localparam int RW = 2 * W;

    logic [RW-1:0] sum;

    // Arithmetic core of the cell.
    always_comb begin
        sum = RW'(a) * RW'(b) + RW'(c) + RW'(s);
    end

    generate
        if (REG_OUT != 0) begin : g_reg
            // Output register variant.
            always_ff @(posedge clk) begin
                if (!rst_n) res <= '0;
                else        res <= sum;
            end
        end else begin : g_comb
            assign res = sum;
        end
    endgenerate
endmodule

// File: rtl/nib_pass_seq.sv
// Pass sequencer: accepts start only when idle, then steps the phase from 1
// up to LAST and returns to idle. Phase 0 means idle.
// 'finish' is high during the final phase of a run.
module nib_pass_seq
    import nib_mult_pkg::*;
#(
    parameter int LAST = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    output logic   busy,
    output phase_t phase,
    output logic   accept,
    output logic   finish
);
    localparam phase_t PH_LAST = phase_t'(LAST);

    assign accept = start && !busy;
    assign finish = busy && (phase == PH_LAST);

    // Phase counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            phase <= phase_t'(1);
        end else if (finish) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (busy) begin
            phase <= phase + phase_t'(1);
        end
    end
endmodule

// File: rtl/nib_pass_operands.sv
// Operand routing per pass. Order: lowA*lowB, lowA*highB, highA*lowB,
// highA*highB. 'prev' is the result of the pass just before the current one;
// 'h1' is the upper nibble kept from the second pass. Phases outside 1..4
// drive zeros into the cell.
module nib_pass_operands
    import nib_mult_pkg::*;
(
    input  phase_t            phase,
    input  logic [OP_W-1:0]   a_q,
    input  logic [OP_W-1:0]   b_q,
    input  logic [CELL_W-1:0] prev,
    input  logic [NIB_W-1:0]  h1,
    output logic [NIB_W-1:0]  ca,
    output logic [NIB_W-1:0]  cb,
    output logic [NIB_W-1:0]  cc,
    output logic [NIB_W-1:0]  cs
);
    logic [NIB_W-1:0] a_lo, a_hi, b_lo, b_hi, p_lo, p_hi;

    assign a_lo = a_q[NIB_W-1:0];
    assign a_hi = a_q[OP_W-1:NIB_W];
    assign b_lo = b_q[NIB_W-1:0];
    assign b_hi = b_q[OP_W-1:NIB_W];
    assign p_lo = prev[NIB_W-1:0];
    assign p_hi = prev[CELL_W-1:NIB_W];

    // Select the cell operands and addends for the current pass.
    always_comb begin
        ca = '0; cb = '0; cc = '0; cs = '0;
        case (phase)
            phase_t'(1): begin ca = a_lo; cb = b_lo; end
            phase_t'(2): begin ca = a_lo; cb = b_hi; cc = p_hi; end
            phase_t'(3): begin ca = a_hi; cb = b_lo; cc = p_lo; end
            phase_t'(4): begin ca = a_hi; cb = b_hi; cc = h1; cs = p_hi; end
            default: ;
        endcase
    end
endmodule

// File: rtl/nib_iter_mult.sv
// 8x8 unsigned multiplier built from four passes of one 4x4 multiply-add cell.
// The operands are held from the accepting edge onward. Partial nibbles are
// collected as pass results appear on the cell output (REG_STAGE cycles late).
// Assumes REG_STAGE is 0 or 1.
module nib_iter_mult
    import nib_mult_pkg::*;
#(
    parameter int REG_STAGE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [OP_W-1:0]   op_a,
    input  logic [OP_W-1:0]   op_b,
    output logic [PROD_W-1:0] product,
    output logic              done
);
    localparam int     LAST   = 4 + REG_STAGE;
    localparam phase_t PH_LO0 = phase_t'(1 + REG_STAGE);
    localparam phase_t PH_H1  = phase_t'(2 + REG_STAGE);
    localparam phase_t PH_LO2 = phase_t'(3 + REG_STAGE);

    logic              busy, accept, finish;
    phase_t            phase;
    logic [OP_W-1:0]   a_q, b_q;
    logic [NIB_W-1:0]  ca, cb, cc, cs;
    logic [CELL_W-1:0] cell_res, res_prev;
    logic [NIB_W-1:0]  lo0_q, h1_q, lo2_q;

    nib_pass_seq #(.LAST(LAST)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .phase(phase), .accept(accept), .finish(finish)
    );

    nib_pass_operands u_ops (
        .phase(phase), .a_q(a_q), .b_q(b_q), .prev(res_prev), .h1(h1_q),
        .ca(ca), .cb(cb), .cc(cc), .cs(cs)
    );

    nib_mac_cell #(.W(NIB_W), .REG_OUT(REG_STAGE)) u_cell (
        .clk(clk), .rst_n(rst_n), .a(ca), .b(cb), .c(cc), .s(cs), .res(cell_res)
    );

    generate
        if (REG_STAGE != 0) begin : g_fwd_reg
            // The cell register already holds the previous pass result.
            assign res_prev = cell_res;
        end else begin : g_fwd_hold
            // Hold the previous pass result for the next pass.
            always_ff @(posedge clk) begin
                if (!rst_n) res_prev <= '0;
                else        res_prev <= cell_res;
            end
        end
    endgenerate

    // Capture the operands when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else if (accept) begin
            a_q <= op_a;
            b_q <= op_b;
        end
    end

    // Collect the partial nibbles and the final product.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo0_q   <= '0;
            h1_q    <= '0;
            lo2_q   <= '0;
            product <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (busy && phase == PH_LO0) lo0_q <= cell_res[NIB_W-1:0];
            if (busy && phase == PH_H1)  h1_q  <= cell_res[CELL_W-1:NIB_W];
            if (busy && phase == PH_LO2) lo2_q <= cell_res[NIB_W-1:0];
            if (finish) product <= {cell_res, lo2_q, lo0_q};
        end
    end
endmodule

// File: rtl/nib_iter_mult_chk.sv
// Checker for nib_iter_mult: keeps its own copy of the accepted operands and
// a latency counter, and checks result, timing and stability.
module nib_iter_mult_chk
    import nib_mult_pkg::*;
#(
    parameter int REG_STAGE = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [OP_W-1:0]   op_a,
    input logic [OP_W-1:0]   op_b,
    input logic [PROD_W-1:0] product,
    input logic              done,
    input logic              busy,
    input logic [OP_W-1:0]   a_q,
    input logic [OP_W-1:0]   b_q
);
    localparam int LAT = 5 + REG_STAGE;

    logic [OP_W-1:0] cap_a, cap_b;
    logic [3:0]      since;

    // Reference copy of the operands and the count of cycles since acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
            since <= '0;
        end else if (start && !busy) begin
            cap_a <= op_a;
            cap_b <= op_b;
            since <= 4'd1;
        end else if (since != 4'd0 && since != 4'd15) begin
            since <= since + 4'd1;
        end
    end

    // R2 R9
    product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == PROD_W'(cap_a) * PROD_W'(cap_b));

    // R3 R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> since == 4'(LAT));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5 R6
    operands_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q)));

    // R7
    product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(product) || done));
endmodule

bind nib_iter_mult nib_iter_mult_chk #(.REG_STAGE(REG_STAGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .product(product), .done(done), .busy(busy), .a_q(a_q), .b_q(b_q)
);

// File: tb/tb_nib_iter_mult.sv
`timescale 1ns/1ps
// Bench: combinational (dut) and registered (dut_pipe) builds run side by side.
module tb_nib_iter_mult;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0, op_b = '0;
    logic [15:0] prod0, prod1;
    logic        done0, done1;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    nib_iter_mult #(.REG_STAGE(0)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .product(prod0), .done(done0)
    );
    nib_iter_mult #(.REG_STAGE(1)) dut_pipe (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .product(prod1), .done(done1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One multiply, starting at a negedge; returns at the negedge where the
    // registered build shows done (its start slot for the next call, R8).
    task automatic run_mul(input logic [7:0] x, input logic [7:0] y, input bit poke);
        int exp = int'(x) * int'(y);
        start = 1'b1; op_a = x; op_b = y;
        @(negedge clk);                       // phase 1
        start = 1'b0; op_a = ~x; op_b = y ^ 8'hA5;   // R6 disturbance
        chk(done0 == 1'b0 && done1 == 1'b0, "R3 no early done", int'(done0), 0);
        @(negedge clk);                       // phase 2
        if (poke) begin                       // R5 start while busy
            start = 1'b1; op_a = 8'd3; op_b = 8'd7;
        end
        @(negedge clk);                       // phase 3
        start = 1'b0;
        @(negedge clk);                       // phase 4
        chk(done0 == 1'b0, "R3 done not before 4th edge", int'(done0), 0);
        @(negedge clk);
        chk(done0 == 1'b1, "R3 done timing", int'(done0), 1);
        chk(int'(prod0) == exp, "R2 R6 product", int'(prod0), exp);
        chk(done1 == 1'b0, "R9 registered build one cycle later", int'(done1), 0);
        @(negedge clk);
        chk(done0 == 1'b0, "R4 single pulse", int'(done0), 0);
        chk(int'(prod0) == exp, "R7 product held", int'(prod0), exp);
        chk(done1 == 1'b1, "R9 registered done timing", int'(done1), 1);
        chk(int'(prod1) == exp, "R9 registered product", int'(prod1), exp);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk(done0 == 1'b0 && done1 == 1'b0, "R1 done in reset", int'(done0 | done1), 0);
        chk(prod0 == 16'd0 && prod1 == 16'd0, "R1 product in reset", int'(prod0 | prod1), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done0 == 1'b0 && prod0 == 16'd0, "R1 after reset", int'(prod0), 0);

        // R5 directed: busy start must not disturb the run or add a pulse.
        run_mul(8'd200, 8'd123, 1'b1);
        @(negedge clk);
        chk(done0 == 1'b0 && done1 == 1'b0, "R5 no extra done", int'(done0 | done1), 0);
        repeat (6) begin
            @(negedge clk);
            chk(done0 == 1'b0 && done1 == 1'b0, "R5 no extra done later", int'(done0 | done1), 0);
        end
        chk(int'(prod0) == 24600 && int'(prod1) == 24600, "R5 R7 result kept", int'(prod0), 24600);

        // R8 directed on the combinational build: start in its done cycle.
        start = 1'b1; op_a = 8'd255; op_b = 8'd255;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(done0 == 1'b1 && int'(prod0) == 65025, "R2 corner 255x255", int'(prod0), 65025);
        start = 1'b1; op_a = 8'd17; op_b = 8'd240;
        @(negedge clk); start = 1'b0;            // dut accepted at its done edge
        chk(done1 == 1'b1 && int'(prod1) == 65025, "R9 corner 255x255", int'(prod1), 65025);
        repeat (3) @(negedge clk);
        @(negedge clk);
        chk(done0 == 1'b1 && int'(prod0) == 4080, "R8 back-to-back accepted", int'(prod0), 4080);
        repeat (4) @(negedge clk);

        // Near-exhaustive sweep, chained back to back (R8 on registered build).
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j += 5) begin
                run_mul(8'(i), 8'(j), 1'b0);
            end
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule